// File: doc/BRIEF.md
# Low-Side Gate Fault Shutdown Controller

This controller sits between the PWM generator and the three low-side gate drivers of a three-phase inverter bridge. It watches an overcurrent comparator and the low-side supply monitors. On a fault it blocks every gate at once through a combinational path. On the next clock edge it turns on an open-drain pull-down on a shutdown line that is shared with the system. The line's voltage arrives only as two digitized flags: one says the line is below the unlatch level, the other says it is above the logic-high level.

While the pull-down is on, a tick counter enforces a minimum hold time that depends on the fault type. The pull-down is released only when three things are true: the fault condition is gone, the line has been seen below the unlatch level, and an off-time has run while the line stayed low. After release, the gates stay blocked until the line climbs back above its logic-high level. Any external RC on the line therefore stretches the restart but never delays the turn-off. Time is counted in pulses of a tick enable, nominally one per microsecond.

Top module: `lsg_fault_ctrl`

## Requirements
- R1: While the overcurrent flag and the supply-above-4V flag are both high, every gate enable is low in that same cycle, whatever the controller state.
- R2: An overcurrent fault turns the pull-down on from the next clock edge. It stays on for at least OC_MIN_TICKS ticks and for as long as the overcurrent flag stays high. It is followed by the off-time of R5, so a one-cycle overcurrent gives exactly OC_MIN_TICKS+OFF_TICKS ticks of pull-down.
- R3: An undervoltage fault holds the pull-down for at least UV_MIN_TICKS ticks and for as long as the lockout lasts, followed by the off-time. A single trip with the supply reported good gives exactly UV_MIN_TICKS+OFF_TICKS ticks.
- R4: Lockout is entered on the turn-off comparator (trip flag) on the next edge. Lockout is left only when the turn-on comparator (ok flag) is high with no trip. Dropping the trip flag alone keeps the pull-down on.
- R5: After the minimum time, the pull-down is released only after OFF_TICKS ticks counted while the below-unlatch flag is high. While that flag stays low, the pull-down stays on.
- R6: After release, gates stay low until the above-logic-high flag is seen. The gates then follow PWM from the second edge on, and the cause code returns to 0. Until then the cause code keeps its value.
- R7: A low shutdown line with no internal fault (above-logic-high flag low) forces every gate low in the same cycle. It does not turn on the pull-down and does not set a cause.
- R8: With the supply-above-4V flag low, the overcurrent flag is ignored. With it high, overcurrent is honoured even during lockout and extends the pull-down past the end of the lockout.
- R9: `fault_o` equals the pull-down. The cause code is 0 for none, 1 for overcurrent and 2 for undervoltage. An undervoltage replaces an overcurrent cause and restarts the hold count.
- R10: After reset the controller is in lockout: pull-down on, gates low, cause 2.
- R11: In normal running, with the line high and no fault, gate enable bit k equals PWM bit k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle timing pulse, nominally 1 MHz |
| pwm_lo_i | input | PHASES | Active-high low-side PWM commands |
| oc_flag_i | input | 1 | Overcurrent comparator output |
| sup_4v_i | input | 1 | Supply is above the comparator-enable level |
| uv_trip_i | input | 1 | Supply below the turn-off threshold |
| uv_ok_i | input | 1 | Supply above the turn-on threshold |
| pin_low_i | input | 1 | Shutdown line below the unlatch level |
| pin_high_i | input | 1 | Shutdown line above the logic-high level |
| gate_en_o | output | PHASES | Low-side gate enables |
| pull_dn_o | output | 1 | Open-drain pull-down enable for the shutdown line |
| fault_o | output | 1 | Fault indication, equal to the pull-down |
| cause_o | output | 2 | Cause of the last shutdown: 0 none, 1 overcurrent, 2 undervoltage |

## Verification
A wrong internal state shows first in the number of ticks the pull-down stays on. A hold counter that clears at the wrong time, or a wrong limit chosen for the fault type, moves the release by whole ticks. The bench measures that span exactly for short faults. A lockout flag that clears without the turn-on comparator shows as an early release, within one off-time. A restart that does not wait for the line shows as gates switching while the above-logic-high flag is still low, within two cycles of release. A cause register that misses its update shows at once on `cause_o`.

// File: rtl/lsg_fault_pkg.sv
// Package: shared state and cause encodings plus a width helper for the
// low-side gate fault controller. Assumes nothing beyond 1800-2017.
package lsg_fault_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_HOLD  = 2'd1,
        ST_DRAIN = 2'd2,
        ST_WAIT  = 2'd3
    } lsg_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_OC   = 2'd1,
        CAUSE_UV   = 2'd2
    } lsg_cause_e;

    // Bits needed to hold the largest of three tick limits.
    function automatic int unsigned lim_width(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        m = (m > c) ? m : c;
        return (m < 1) ? 1 : $clog2(m + 1);
    endfunction

endpackage

// File: rtl/lsg_uv_hyst.sv
// Undervoltage hysteresis latch. Enters lockout on the turn-off
// comparator and leaves it only on the turn-on comparator. Trip wins
// when both are high. Assumes both flags are synchronous to clk.
module lsg_uv_hyst (
    input  logic clk,
    input  logic rst_n,
    input  logic trip_i,
    input  logic ok_i,
    output logic lock_o
);
    logic lock_q;

    // Holds the lockout state between the two thresholds.
    always_ff @(posedge clk) begin
        if (!rst_n)      lock_q <= 1'b1;
        else if (trip_i) lock_q <= 1'b1;
        else if (ok_i)   lock_q <= 1'b0;
    end

    assign lock_o = lock_q;
endmodule

// File: rtl/lsg_tick_cnt.sv
// Saturating tick counter with a synchronous clear. Clear wins over
// increment. Used for both the hold and the off-time phases.
module lsg_tick_cnt #(
    parameter int unsigned W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] CNT_TOP = {W{1'b1}};
    logic [W-1:0] cnt_q;

    // Counts qualified ticks and stops at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)               cnt_q <= '0;
        else if (inc_i && cnt_q != CNT_TOP) cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/lsg_gate_mux.sv
// Per-phase gate gating. Each gate enable is its PWM bit ANDed with a
// shared permit. Purely combinational so a fault cut needs no clock edge.
module lsg_gate_mux #(
    parameter int unsigned PHASES = 3
) (
    input  logic [PHASES-1:0] pwm_i,
    input  logic              allow_i,
    output logic [PHASES-1:0] gate_o
);
    for (genvar k = 0; k < PHASES; k++) begin : g_phase
        assign gate_o[k] = pwm_i[k] & allow_i;
    end
endmodule

// File: rtl/lsg_fault_ctrl.sv
// Low-side gate fault shutdown controller (top). Blocks gates at once on
// a fault, holds the shutdown-line pull-down for a fault-dependent
// minimum, then an off-time counted while the line reads low, and
// restarts the gates only when the line reads high again.
// Assumes every input is already synchronous to clk.
module lsg_fault_ctrl #(
    parameter int unsigned PHASES       = 3,
    parameter int unsigned OC_MIN_TICKS = 20,
    parameter int unsigned UV_MIN_TICKS = 50,
    parameter int unsigned OFF_TICKS    = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [PHASES-1:0] pwm_lo_i,
    input  logic              oc_flag_i,
    input  logic              sup_4v_i,
    input  logic              uv_trip_i,
    input  logic              uv_ok_i,
    input  logic              pin_low_i,
    input  logic              pin_high_i,
    output logic [PHASES-1:0] gate_en_o,
    output logic              pull_dn_o,
    output logic              fault_o,
    output logic [1:0]        cause_o
);
    import lsg_fault_pkg::*;

    localparam int unsigned CW = lim_width(OC_MIN_TICKS, UV_MIN_TICKS, OFF_TICKS);
    localparam logic [CW-1:0] OC_LIM  = CW'(OC_MIN_TICKS);
    localparam logic [CW-1:0] UV_LIM  = CW'(UV_MIN_TICKS);
    localparam logic [CW-1:0] OFF_LIM = CW'(OFF_TICKS);

    lsg_state_e    state_q, state_d;
    lsg_cause_e    cause_q, cause_d;
    logic          uv_lock;
    logic          cnt_clr, cnt_inc;
    logic [CW-1:0] cnt;
    logic          oc_live, uv_live, hold_done, allow;

    lsg_uv_hyst u_hyst (
        .clk    (clk),
        .rst_n  (rst_n),
        .trip_i (uv_trip_i),
        .ok_i   (uv_ok_i),
        .lock_o (uv_lock)
    );

    lsg_tick_cnt #(.W(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (cnt_clr),
        .inc_i (cnt_inc),
        .cnt_o (cnt)
    );

    // Qualified fault sources: overcurrent needs the 4 V supply flag.
    assign oc_live   = oc_flag_i & sup_4v_i;
    assign uv_live   = uv_trip_i | uv_lock;
    assign hold_done = (cause_q == CAUSE_UV) ? (cnt >= UV_LIM) : (cnt >= OC_LIM);

    // Hold phase counts every tick; drain phase only ticks with the line low.
    assign cnt_inc = tick_en &
                     ((state_q == ST_HOLD) | ((state_q == ST_DRAIN) & pin_low_i));

    // Next state, cause and counter clear.
    always_comb begin
        state_d = state_q;
        cause_d = cause_q;
        cnt_clr = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (uv_live) begin
                    state_d = ST_HOLD; cause_d = CAUSE_UV; cnt_clr = 1'b1;
                end else if (oc_live) begin
                    state_d = ST_HOLD; cause_d = CAUSE_OC; cnt_clr = 1'b1;
                end
            end
            ST_HOLD: begin
                if (uv_live && cause_q != CAUSE_UV) begin
                    cause_d = CAUSE_UV; cnt_clr = 1'b1;
                end else if (hold_done && !uv_live && !oc_live) begin
                    state_d = ST_DRAIN; cnt_clr = 1'b1;
                end
            end
            ST_DRAIN, ST_WAIT: begin
                if (uv_live) begin
                    state_d = ST_HOLD; cause_d = CAUSE_UV; cnt_clr = 1'b1;
                end else if (oc_live) begin
                    state_d = ST_HOLD; cause_d = CAUSE_OC; cnt_clr = 1'b1;
                end else if (state_q == ST_DRAIN) begin
                    if (cnt >= OFF_LIM && pin_low_i) state_d = ST_WAIT;
                end else if (pin_high_i) begin
                    state_d = ST_RUN; cause_d = CAUSE_NONE;
                end
            end
            default: state_d = ST_HOLD;
        endcase
    end

    // State and cause registers; reset lands in undervoltage lockout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
            cause_q <= CAUSE_UV;
        end else begin
            state_q <= state_d;
            cause_q <= cause_d;
        end
    end

    // Direct cut path: no register between a live fault and the gates.
    assign allow = (state_q == ST_RUN) & pin_high_i & ~oc_live & ~uv_live;

    lsg_gate_mux #(.PHASES(PHASES)) u_gates (
        .pwm_i   (pwm_lo_i),
        .allow_i (allow),
        .gate_o  (gate_en_o)
    );

    assign pull_dn_o = (state_q == ST_HOLD) | (state_q == ST_DRAIN);
    assign fault_o   = pull_dn_o;
    assign cause_o   = cause_q;
endmodule

// File: rtl/lsg_fault_ctrl_chk.sv
// Checker for lsg_fault_ctrl, bound into every instance. Keeps its own
// tick count of the current pull-down span to check the minimum window.
module lsg_fault_ctrl_chk #(
    parameter int unsigned PHASES       = 3,
    parameter int unsigned OC_MIN_TICKS = 20,
    parameter int unsigned OFF_TICKS    = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              oc_flag_i,
    input logic              sup_4v_i,
    input logic              uv_trip_i,
    input logic              pin_low_i,
    input logic              pin_high_i,
    input logic [PHASES-1:0] gate_en_o,
    input logic              pull_dn_o,
    input logic [1:0]        cause_o
);
    logic [15:0] pd_ticks;

    // Ticks seen during the current pull-down span.
    always_ff @(posedge clk) begin
        if (!rst_n || !pull_dn_o)                  pd_ticks <= '0;
        else if (tick_en && pd_ticks != 16'hFFFF) pd_ticks <= pd_ticks + 1'b1;
    end

    assert_oc_cuts_gates_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_flag_i && sup_4v_i) |-> (gate_en_o == '0));

    assert_min_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pull_dn_o) |-> (pd_ticks >= 16'(OC_MIN_TICKS + OFF_TICKS)));

    assert_trip_pulls_R4: assert property (@(posedge clk) disable iff (!rst_n)
        uv_trip_i |=> pull_dn_o);

    assert_release_needs_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pull_dn_o) |-> $past(pin_low_i));

    assert_no_gate_in_pull_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pull_dn_o |-> (gate_en_o == '0));

    assert_line_low_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_high_i |-> (gate_en_o == '0));

    assert_pull_has_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pull_dn_o |-> (cause_o != 2'd0));
endmodule

bind lsg_fault_ctrl lsg_fault_ctrl_chk #(
    .PHASES       (PHASES),
    .OC_MIN_TICKS (OC_MIN_TICKS),
    .OFF_TICKS    (OFF_TICKS)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .oc_flag_i  (oc_flag_i),
    .sup_4v_i   (sup_4v_i),
    .uv_trip_i  (uv_trip_i),
    .pin_low_i  (pin_low_i),
    .pin_high_i (pin_high_i),
    .gate_en_o  (gate_en_o),
    .pull_dn_o  (pull_dn_o),
    .cause_o    (cause_o)
);

// File: tb/lsg_fault_ctrl_tb_top.sv
// Directed bench for lsg_fault_ctrl. Models the shutdown line as pulled
// low by the pull-down or externally, rising with an RC delay.
module lsg_fault_ctrl_tb_top;
    localparam int OC_T = 20, UV_T = 50, OFF_T = 20, RC_DLY = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic [2:0] pwm = 3'b000;
    logic       oc = 1'b0, sup4 = 1'b1, trip = 1'b0, uvok = 1'b0;
    logic       ext_low = 1'b0, stuck = 1'b0;
    logic       pin_low, pin_high;
    logic [2:0] gate;
    logic       pd, flt;
    logic [1:0] cause;
    int         rc_cnt = 0, div = 0, total = 0, bad = 0, cyc = 0;

    always #2 clk = ~clk;

    // Tick every fourth cycle, updated at the active edge.
    always @(posedge clk) begin
        div     <= (div == 3) ? 0 : div + 1;
        tick_en <= (div == 3);
    end

    // Line model: low while pulled, rises RC_DLY cycles after release.
    assign pin_low  = (pd & ~stuck) | ext_low;
    assign pin_high = ~pin_low && (rc_cnt >= RC_DLY);
    always @(posedge clk) begin
        if (pin_low)              rc_cnt <= 0;
        else if (rc_cnt < RC_DLY) rc_cnt <= rc_cnt + 1;
    end

    lsg_fault_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .pwm_lo_i(pwm),
        .oc_flag_i(oc), .sup_4v_i(sup4), .uv_trip_i(trip), .uv_ok_i(uvok),
        .pin_low_i(pin_low), .pin_high_i(pin_high), .gate_en_o(gate),
        .pull_dn_o(pd), .fault_o(flt), .cause_o(cause)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Counts ticks while the pull-down is on; waits for it to rise first.
    task automatic pull_ticks(output int t);
        t = 0;
        while (!pd) @(negedge clk);
        while (pd) begin
            if (tick_en) t++;
            @(negedge clk);
        end
    endtask

    task automatic settle_run();
        while (!(pin_high && !pd)) @(negedge clk);
        idle(2);
    endtask

    task automatic t_reset();
        @(negedge clk); rst_n = 1'b1;
        check(pd == 1'b1 && flt == 1'b1, "R10 pulldown", pd, 1);
        check(gate == 3'b000, "R10 gates", gate, 0);
        check(cause == 2'd2, "R10 cause", cause, 2);
    endtask

    task automatic t_startup();
        int t;
        uvok = 1'b1;
        t = 0;
        while (pd) begin
            if (tick_en) t++;
            @(negedge clk);
        end
        check(t == UV_T + OFF_T, "R3 startup hold", t, UV_T + OFF_T);
        settle_run();
        check(cause == 2'd0, "R6 cause cleared", cause, 0);
    endtask

    task automatic t_follow();
        for (int p = 0; p < 8; p++) begin
            pwm = 3'(p);
            @(negedge clk);
            check(gate == pwm, "R11 follow", gate, pwm);
        end
    endtask

    task automatic t_oc_short();
        int t;
        pwm = 3'b101; oc = 1'b1; #1;
        check(gate == 3'b000, "R1 same-cycle cut", gate, 0);
        @(negedge clk); oc = 1'b0;
        check(cause == 2'd1 && flt == pd, "R9 oc cause", cause, 1);
        pull_ticks(t);
        check(t == OC_T + OFF_T, "R2 short oc hold", t, OC_T + OFF_T);
        check(gate == 3'b000 && !pin_high, "R6 blocked before line high", gate, 0);
        check(cause == 2'd1, "R6 cause kept", cause, 1);
        settle_run();
        check(gate == 3'b101 && cause == 2'd0, "R6 restart", gate, 5);
    endtask

    task automatic t_oc_long();
        int t;
        oc = 1'b1;
        idle(4 * 60);
        check(pd == 1'b1, "R2 held while oc", pd, 1);
        oc = 1'b0;
        t = 0;
        while (pd) begin
            if (tick_en) t++;
            @(negedge clk);
        end
        check(t >= OFF_T && t <= OFF_T + 1, "R2 release after oc", t, OFF_T);
        settle_run();
    endtask

    task automatic t_hyst();
        int t;
        uvok = 1'b0; trip = 1'b1;
        @(negedge clk); trip = 1'b0;
        idle(4 * 80);
        check(pd == 1'b1 && cause == 2'd2, "R4 lockout kept", pd, 1);
        uvok = 1'b1;
        t = 0;
        while (pd) begin
            if (tick_en) t++;
            @(negedge clk);
        end
        check(t >= OFF_T && t <= OFF_T + 1, "R4 release on ok", t, OFF_T);
        settle_run();
    endtask

    task automatic t_uv_min();
        int t;
        trip = 1'b1; #1;
        check(gate == 3'b000, "R3 trip cuts gates", gate, 0);
        @(negedge clk); trip = 1'b0;
        pull_ticks(t);
        check(t == UV_T + OFF_T, "R3 uv hold", t, UV_T + OFF_T);
        settle_run();
    endtask

    task automatic t_line_slow();
        int t;
        stuck = 1'b1; oc = 1'b1;
        @(negedge clk); oc = 1'b0;
        idle(4 * 60);
        check(pd == 1'b1, "R5 held while line high", pd, 1);
        stuck = 1'b0;
        t = 0;
        while (pd) begin
            if (tick_en) t++;
            @(negedge clk);
        end
        check(t >= OFF_T && t <= OFF_T + 1, "R5 off-time", t, OFF_T);
        settle_run();
    endtask

    task automatic t_ext_low();
        pwm = 3'b111; ext_low = 1'b1; #1;
        check(gate == 3'b000, "R7 ext low cut", gate, 0);
        idle(10);
        check(pd == 1'b0 && cause == 2'd0, "R7 no fault", pd, 0);
        ext_low = 1'b0;
        settle_run();
        check(gate == 3'b111, "R7 resume", gate, 7);
    endtask

    task automatic t_sup4();
        int t;
        sup4 = 1'b0; oc = 1'b1;
        idle(10);
        check(gate == 3'b111 && pd == 1'b0, "R8 oc ignored", gate, 7);
        oc = 1'b0; sup4 = 1'b1;
        trip = 1'b1;
        @(negedge clk); trip = 1'b0; oc = 1'b1;
        idle(4 * 100);
        check(pd == 1'b1 && cause == 2'd2, "R8 oc in lockout", pd, 1);
        oc = 1'b0;
        t = 0;
        while (pd) begin
            if (tick_en) t++;
            @(negedge clk);
        end
        check(t >= OFF_T && t <= OFF_T + 1, "R8 release", t, OFF_T);
        settle_run();
    endtask

    initial begin
        idle(3);
        t_reset();
        t_startup();
        t_follow();
        t_oc_short();
        t_oc_long();
        t_hyst();
        t_uv_min();
        t_line_slow();
        t_ext_low();
        t_sup4();
        finish_run();
    end
endmodule